// File: doc/BRIEF.md
# Weighted Round-Robin Queue Scheduler

This block decides which of the output queues attached to a single port may send next. Each queue has a stored priority setting from 0 to 9. Settings 0 to 8 become fixed 8-bit round-enable masks whose set bits are spread across eight scheduling rounds. A round counter steps through those rounds, and in each round the queues whose mask bit is set are served in ascending queue order, each at most once. Setting 9 places a queue in a strict-priority group. That group is always served ahead of the weighted queues, and the lowest queue number in it wins.

The surrounding logic supplies one not-empty flag per queue and writes priority settings through a one-word configuration port. It takes a grant back as a one-hot vector plus an index. A grant stays presented until the consumer accepts it with the acknowledge input. Settings may be rewritten while traffic is flowing. Two status outputs flag a strict-priority group that is not a contiguous run starting at queue 0, and a stored setting above 9. Two per-grant flags mark the port's last queue and the last queue of the strict group.

Top module: `wrr_queue_sched`

## Requirements
- R1: Settings 0..8 select the round-enable masks 8'h00, 8'h01, 8'h11, 8'h49, 8'h55, 8'h57, 8'h77, 8'h7F and 8'hFF. Mask bit r enables the queue in round r (bit 0 is round 0), and rounds run 0,1,...,7 and then wrap to 0.
- R2: A queue with setting 0 is never granted. A queue with setting 8 that stays non-empty receives eight grants for every one granted to a queue with setting 1.
- R3: Setting 9 marks a strict queue, whose mask counts as 8'hFF. While any strict queue is non-empty, the grant goes to the lowest-numbered non-empty strict queue, whatever the round.
- R4: cfg_bad_strict is high exactly when the set of strict queues is not empty and is not a contiguous run starting at queue 0.
- R5: grant_tail is high when the granted queue is queue NQ-1. grant_stail is high when the granted queue is strict and the next higher queue is not strict or does not exist.
- R6: A stored setting of 10..15 raises cfg_bad_value and acts as a weighted queue with mask 8'hFF. cfg_bad_value falls once no such setting is stored.
- R7: Within a round, weighted queues are granted in ascending order, starting after the last one accepted in that round. When none remains, one cycle passes with no grant, and the round advances with the search restarting at queue 0.
- R8: When no queue is non-empty with a non-zero weighted mask and no strict queue is non-empty, grant_valid stays low and the round does not change.
- R9: A grant stays on the same queue until grant_ack is high in a cycle where grant_valid is high. The acceptance is consumed at that clock edge.
- R10: After reset every setting is 8 and the round is 0. A write with cfg_we takes effect from the next cycle, including while grants are being accepted.
- R11: grant is one-hot or zero, grant_valid equals the OR of grant, grant_idx names the set bit, and only a non-empty queue is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for a priority setting |
| cfg_qid | input | QW | Queue whose setting is written |
| cfg_prio | input | PW | New priority setting (0..8 weighted, 9 strict) |
| q_nonempty | input | NQ | Per-queue not-empty flags |
| grant_ack | input | 1 | Consumer accepts the presented grant |
| grant | output | NQ | One-hot grant vector |
| grant_valid | output | 1 | A grant is presented |
| grant_idx | output | QW | Index of the granted queue |
| grant_tail | output | 1 | Granted queue is the port's last queue |
| grant_stail | output | 1 | Granted queue is the last of the strict group |
| cfg_bad_strict | output | 1 | Strict queues are not a contiguous run from queue 0 |
| cfg_bad_value | output | 1 | Some stored setting is above 9 |

## Verification
The bench builds the block with its defaults, NQ = 8 and PW = 4. This makes the full space reachable in small sweeps. Every setting 0..8 on every queue is run alone over one full eight-round cycle, and the per-cycle grant sequence is compared with the spacing its mask implies. All 256 subsets of strict queues are swept, checking the contiguity flag, the winning queue and the strict-tail flag against arithmetic on the subset. The remaining cases cover the 8:1 ratio between settings 8 and 1, in-round ordering, an out-of-range setting, holding without acknowledge, idle holding of the round, and a live setting change.

// File: rtl/wrr_queue_sched.sv
module wrr_queue_sched #(
  parameter int NQ = 8,
  parameter int PW = 4,
  parameter logic [PW-1:0] PRIO_STRICT = PW'(9),
  parameter logic [PW-1:0] PRIO_RESET = PW'(8),
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [QW-1:0] cfg_qid,
  input  logic [PW-1:0] cfg_prio,
  input  logic [NQ-1:0] q_nonempty,
  input  logic          grant_ack,
  output logic [NQ-1:0] grant,
  output logic          grant_valid,
  output logic [QW-1:0] grant_idx,
  output logic          grant_tail,
  output logic          grant_stail,
  output logic          cfg_bad_strict,
  output logic          cfg_bad_value
);

  localparam int RW = 3;

  function automatic logic [7:0] round_mask(input logic [PW-1:0] p);
    case (p)
      PW'(0):  round_mask = 8'h00;
      PW'(1):  round_mask = 8'h01;
      PW'(2):  round_mask = 8'h11;
      PW'(3):  round_mask = 8'h49;
      PW'(4):  round_mask = 8'h55;
      PW'(5):  round_mask = 8'h57;
      PW'(6):  round_mask = 8'h77;
      PW'(7):  round_mask = 8'h7F;
      default: round_mask = 8'hFF;
    endcase
  endfunction

  logic [PW-1:0] prio_q [NQ];
  logic [RW-1:0] rnd_q;
  logic [QW:0]   start_q;

  logic [NQ-1:0] strict_v, live_w, elig_r, stail_v, bad_v;
  logic [NQ-1:0] strict_pend;
  logic [QW-1:0] s_idx, w_idx, sel;
  logic          use_s;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [7:0] m;
    assign m           = round_mask(prio_q[q]);
    assign strict_v[q] = (prio_q[q] == PRIO_STRICT);
    assign bad_v[q]    = (prio_q[q] > PRIO_STRICT);
    assign live_w[q]   = q_nonempty[q] & ~strict_v[q] & (m != 8'h00);
    assign elig_r[q]   = live_w[q] & m[rnd_q] & ((QW+1)'(q) >= start_q);
    if (q == NQ - 1) begin : g_last
      assign stail_v[q] = strict_v[q];
    end else begin : g_mid
      assign stail_v[q] = strict_v[q] & ~strict_v[q+1];
    end
  end

  assign strict_pend = q_nonempty & strict_v;

  always_comb begin
    s_idx = '0;
    w_idx = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (strict_pend[i]) s_idx = QW'(i);
      if (elig_r[i])      w_idx = QW'(i);
    end
  end

  assign use_s       = |strict_pend;
  assign grant_valid = use_s | (|elig_r);
  assign sel         = use_s ? s_idx : w_idx;
  assign grant_idx   = grant_valid ? sel : '0;
  assign grant       = grant_valid ? (NQ'(1) << sel) : '0;
  assign grant_tail  = grant_valid && (sel == QW'(NQ - 1));
  assign grant_stail = |(grant & stail_v);

  assign cfg_bad_strict = |(strict_v & (strict_v + NQ'(1)));
  assign cfg_bad_value  = |bad_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) prio_q[i] <= PRIO_RESET;
      rnd_q   <= '0;
      start_q <= '0;
    end else begin
      if (cfg_we && (32'(cfg_qid) < NQ)) prio_q[cfg_qid] <= cfg_prio;
      if (grant_valid && !use_s && grant_ack) begin
        start_q <= (QW+1)'(sel) + (QW+1)'(1);
      end else if (!grant_valid && (|live_w)) begin
        rnd_q   <= rnd_q + RW'(1);
        start_q <= '0;
      end
    end
  end

endmodule

// File: rtl/wrr_queue_sched_chk.sv
module wrr_queue_sched_chk #(
  parameter int NQ = 8,
  parameter int PW = 4,
  parameter logic [PW-1:0] PRIO_STRICT = PW'(9),
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NQ-1:0] q_nonempty,
  input logic [NQ-1:0] grant,
  input logic          grant_valid,
  input logic [QW-1:0] grant_idx,
  input logic [PW-1:0] prio_q [NQ],
  input logic [2:0]    rnd_q,
  input logic [NQ-1:0] live_w
);

  logic [NQ-1:0] strict_c;
  for (genvar q = 0; q < NQ; q++) begin : g_s
    assign strict_c[q] = (prio_q[q] == PRIO_STRICT);
  end

  assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_valid == (grant != '0)));

  assert_grant_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (q_nonempty[grant_idx] && grant[grant_idx]));

  assert_zero_never_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (prio_q[grant_idx] != '0));

  assert_strict_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(q_nonempty & strict_c)) |-> (grant_valid && strict_c[grant_idx]));

  assert_round_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && !(|live_w)) |=> (rnd_q == $past(rnd_q)));

  assert_round_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> (rnd_q == $past(rnd_q)));

endmodule

bind wrr_queue_sched wrr_queue_sched_chk #(.NQ(NQ), .PW(PW), .PRIO_STRICT(PRIO_STRICT)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_nonempty(q_nonempty), .grant(grant),
  .grant_valid(grant_valid), .grant_idx(grant_idx), .prio_q(prio_q),
  .rnd_q(rnd_q), .live_w(live_w)
);

// File: tb/wrr_queue_sched_test.sv
module wrr_queue_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 8;
  localparam int PW = 4;
  localparam int QW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [QW-1:0] cfg_qid = '0;
  logic [PW-1:0] cfg_prio = '0;
  logic [NQ-1:0] q_nonempty = '0;
  logic          grant_ack = 1'b0;
  logic [NQ-1:0] grant;
  logic          grant_valid;
  logic [QW-1:0] grant_idx;
  logic          grant_tail, grant_stail, cfg_bad_strict, cfg_bad_value;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrr_queue_sched #(.NQ(NQ), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_prio(cfg_prio),
    .q_nonempty(q_nonempty), .grant_ack(grant_ack), .grant(grant),
    .grant_valid(grant_valid), .grant_idx(grant_idx), .grant_tail(grant_tail),
    .grant_stail(grant_stail), .cfg_bad_strict(cfg_bad_strict), .cfg_bad_value(cfg_bad_value)
  );

  function automatic logic [7:0] exp_mask(input int p);
    case (p)
      0: exp_mask = 8'h00; 1: exp_mask = 8'h01; 2: exp_mask = 8'h11;
      3: exp_mask = 8'h49; 4: exp_mask = 8'h55; 5: exp_mask = 8'h57;
      6: exp_mask = 8'h77; 7: exp_mask = 8'h7F; default: exp_mask = 8'hFF;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 1'b0; q_nonempty = '0; grant_ack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int q, input int p);
    cfg_we = 1'b1; cfg_qid = QW'(q); cfg_prio = PW'(p);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_all(input int p);
    for (int i = 0; i < NQ; i++) wr(i, p);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c0, c1, cnt;
    logic [15:0] act_seq, exp_seq;
    int n;

    // R10 reset state
    do_reset();
    #1;
    chk("R10 reset grant_valid", grant_valid, 0);
    chk("R10 reset grant", int'(grant), 0);
    chk("R4 reset bad_strict", cfg_bad_strict, 0);
    chk("R6 reset bad_value", cfg_bad_value, 0);
    q_nonempty = 8'h01;
    #1;
    chk("R10 reset prio 8 round 0 grant", int'(grant_valid), 1);
    chk("R11 reset grant vector", int'(grant), 1);
    @(negedge clk);

    // R1 mask sweep: every setting on every queue, one full 8-round cycle
    for (int q = 0; q < NQ; q++) begin
      for (int p = 0; p <= 8; p++) begin
        logic [7:0] m;
        do_reset();
        for (int i = 0; i < NQ; i++) wr(i, (i == q) ? p : 0);
        m = exp_mask(p);
        exp_seq = '0; n = 0;
        for (int r = 0; r < 8; r++) begin
          if (m[r]) begin exp_seq[n] = 1'b1; n = n + 2; end
          else n = n + 1;
        end
        act_seq = '0;
        q_nonempty = NQ'(1) << q;
        grant_ack = 1'b1;
        for (int k = 0; k < n; k++) begin
          #1;
          act_seq[k] = grant_valid && (grant_idx == QW'(q)) && (grant == (NQ'(1) << q));
          @(negedge clk);
        end
        chk($sformatf("R1 mask sequence q%0d p%0d", q, p), int'(act_seq), int'(exp_seq));
        grant_ack = 1'b0; q_nonempty = '0;
      end
    end

    // R2 ratio setting 8 vs 1
    do_reset();
    wr_all(0); wr(0, 8); wr(1, 1);
    q_nonempty = 8'h03; grant_ack = 1'b1; c0 = 0; c1 = 0;
    for (int k = 0; k < 17; k++) begin
      #1;
      if (grant_valid && grant_idx == 0) c0++;
      if (grant_valid && grant_idx == 1) c1++;
      @(negedge clk);
    end
    chk("R2 grants to setting 8", c0, 8);
    chk("R2 grants to setting 1", c1, 1);
    grant_ack = 1'b0; q_nonempty = '0;

    // R7 in-round ascending order then idle cycle
    do_reset();
    q_nonempty = 8'hFF; grant_ack = 1'b1;
    for (int k = 0; k < 8; k++) begin
      #1;
      chk($sformatf("R7 round order slot %0d", k), int'(grant_idx), k);
      @(negedge clk);
    end
    #1;
    chk("R7 idle cycle at round end", grant_valid, 0);
    @(negedge clk);
    #1;
    chk("R7 next round restarts at 0", int'(grant_idx), 0);
    @(negedge clk);
    grant_ack = 1'b0; q_nonempty = '0;

    // R5 tail flag
    do_reset();
    q_nonempty = 8'h80;
    #1;
    chk("R5 tail on last queue", grant_tail, 1);
    chk("R5 no stail on weighted", grant_stail, 0);
    q_nonempty = 8'h10;
    #1;
    chk("R5 no tail on queue 4", grant_tail, 0);
    q_nonempty = '0;
    @(negedge clk);

    // R3 R4 R5 strict subset sweep
    do_reset();
    for (int s = 0; s < 256; s++) begin
      logic [8:0] sv;
      int lo, exp_st;
      q_nonempty = '0;
      for (int i = 0; i < NQ; i++) wr(i, s[i] ? 9 : 8);
      sv = 9'(s);
      q_nonempty = 8'hFF;
      #1;
      chk($sformatf("R4 bad_strict set %0d", s), cfg_bad_strict,
          int'(((sv & (sv + 9'd1)) & 9'h0FF) != 0));
      lo = 0;
      for (int i = NQ - 1; i >= 0; i--) if (s[i]) lo = i;
      exp_st = (s != 0) && ((lo == 7) || !s[lo + 1]);
      chk($sformatf("R3 strict winner set %0d", s), int'(grant_idx), lo);
      chk($sformatf("R5 stail set %0d", s), grant_stail, exp_st);
      q_nonempty = '0;
    end
    do_reset();

    // R3 strict served ahead, lower queue first
    wr(0, 9); wr(1, 9); wr(2, 8);
    q_nonempty = 8'h07; grant_ack = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R3 queue 0 keeps winning", int'(grant_idx), 0);
      @(negedge clk);
    end
    q_nonempty = 8'h06;
    #1;
    chk("R3 queue 1 after queue 0 drains", int'(grant_idx), 1);
    chk("R5 stail on queue 1", grant_stail, 1);
    @(negedge clk);
    q_nonempty = 8'h04;
    #1;
    chk("R3 weighted after strict drains", int'(grant_idx), 2);
    @(negedge clk);
    grant_ack = 1'b0; q_nonempty = '0;

    // R6 out-of-range setting
    do_reset();
    wr_all(0); wr(2, 12);
    #1;
    chk("R6 bad_value raised", cfg_bad_value, 1);
    chk("R4 out-of-range not strict", cfg_bad_strict, 0);
    q_nonempty = 8'h04; grant_ack = 1'b1; cnt = 0;
    for (int k = 0; k < 16; k++) begin
      #1;
      if (grant_valid && grant_idx == 2) cnt++;
      @(negedge clk);
    end
    chk("R6 behaves as mask FF", cnt, 8);
    grant_ack = 1'b0; q_nonempty = '0;
    wr(2, 3);
    #1;
    chk("R6 bad_value cleared", cfg_bad_value, 0);
    @(negedge clk);

    // R9 hold until ack
    do_reset();
    q_nonempty = 8'h28;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R9 grant held without ack", int'(grant_idx), 3);
      @(negedge clk);
    end
    grant_ack = 1'b1;
    #1;
    chk("R9 grant before ack edge", int'(grant_idx), 3);
    @(negedge clk);
    grant_ack = 1'b0;
    #1;
    chk("R9 next queue after ack", int'(grant_idx), 5);
    @(negedge clk);
    q_nonempty = '0;

    // R8 hold when nothing eligible
    do_reset();
    wr_all(0);
    q_nonempty = 8'hFF; grant_ack = 1'b1; cnt = 0;
    for (int k = 0; k < 20; k++) begin
      #1;
      if (grant_valid) cnt++;
      @(negedge clk);
    end
    chk("R8 no grant with all settings 0", cnt, 0);
    chk("R8 grant vector low", int'(grant), 0);
    wr(6, 1);
    #1;
    chk("R8 round held at 0 so setting 1 wins", int'(grant_valid && grant_idx == 6), 1);
    grant_ack = 1'b0; q_nonempty = '0;
    @(negedge clk);

    // R10 live change of a setting
    do_reset();
    q_nonempty = 8'hFF; grant_ack = 1'b1;
    for (int k = 0; k < 9; k++) @(negedge clk);
    wr(5, 0);
    cnt = 0; c0 = 0;
    for (int k = 0; k < 18; k++) begin
      #1;
      if (grant_valid && grant_idx == 5) cnt++;
      if (grant_valid) c0++;
      @(negedge clk);
    end
    chk("R10 queue 5 off after live write", cnt, 0);
    chk("R10 other queues still served", int'(c0 >= 12), 1);
    grant_ack = 1'b0; q_nonempty = '0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule